// File: doc/BRIEF.md
# Serial Frame Transmitter with Character Queue

This block is the sending half of an asynchronous serial port. Software pushes characters of up to nine bits into a sixteen-entry queue through a register write port. A serializer takes characters from the queue one at a time and shifts each one out on a single line. It uses a 16x oversampling tick supplied by an external baud-rate generator.

The serializer supports five character formats. These are plain 8-bit, 7-bit with parity, 9-bit, 8-bit with an extra wake-up bit, and 8-bit with parity. It also offers four stop lengths, from half a bit to two bits. The queue reports empty, half-empty and full conditions in a status word. Two of these conditions can raise an interrupt when enabled. A clear-to-send input can hold the next character back while flow control is on.

Top module: `sertx_top`

## Requirements
- R1: After reset the line `tx` is high, `status` reads 0x006 (bit 1 and bit 2 set, bit 9 clear), and the queue is empty.
- R2: A `reg_wr` pulse with `reg_addr` equal to 0x04 appends `reg_wdata[8:0]` to the queue when the queue holds fewer than 16 entries. A write while the queue holds 16 entries is dropped. A write to any other address has no effect.
- R3: `status[2]` is 1 whenever the queue holds 8 or fewer entries. `status[9]` is 1 exactly when it holds 16. The change is visible the cycle after the write or pop edge.
- R4: `status[1]` (transmitter empty) is 1 only while the queue is empty and the serializer has completed the last tick of its final stop period.
- R5: The line idles high. A frame begins on a clock edge where `baud_tick` is 1: the line drives a 0 start bit, then the payload least-significant bit first. Every start and payload bit lasts exactly 16 ticks.
- R6: `mode` selects the payload. 3'b001 sends data[7:0]. 3'b011 sends data[6:0] then parity. 3'b100 sends data[8:0]. 3'b101 sends data[7:0] then data[8] as the wake-up bit. 3'b111 sends data[7:0] then parity. Any other code behaves as 3'b001.
- R7: With `parity_odd` at 0 the parity bit makes the count of ones over data and parity even. With `parity_odd` at 1 it makes that count odd.
- R8: `stop_sel` gives a high stop period of 8 (2'b00), 16 (2'b01), 24 (2'b10) or 32 (2'b11) ticks. The next queued frame may start on the tick that ends the stop period.
- R9: With `cts_gate` at 1 and `cts` at 0 no new frame starts. A frame already in progress runs to its end.
- R10: A `fifo_clr` pulse empties the queue and takes precedence over a write in the same cycle. A frame already being shifted still completes.
- R11: `irq` is 1 exactly when (`irq_en[1]` and `status[1]`) or (`irq_en[2]` and `status[2]`).
- R12: `mode`, `parity_odd` and `stop_sel` are captured when a frame starts. Changing them mid-frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register write address |
| reg_wdata | input | 9 | Character to queue |
| fifo_clr | input | 1 | Queue clear strobe |
| mode | input | 3 | Character format select |
| stop_sel | input | 2 | Stop length select |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| cts_gate | input | 1 | Enables clear-to-send gating |
| irq_en | input | 2 (bits 2:1) | Interrupt enables for half-empty (2) and empty (1) |
| baud_tick | input | 1 | 16x oversampling tick |
| cts | input | 1 | Clear to send, active high |
| tx | output | 1 | Serial line |
| status | output | 10 | bit 1 empty, bit 2 half-empty, bit 9 full, others 0 |
| irq | output | 1 | Interrupt request |

## Verification
A write or clear becomes visible on `status` and `irq` one clock after the edge that samples it. The `tx` line changes on the same edge that samples a `baud_tick`, and a bit boundary falls every 16 sampled ticks. The bench keeps a behavioural model built from queues and integers, advances it on each rising edge from the same inputs, and compares `tx`, `status` and `irq` on the following falling edge. Every expected value is therefore due exactly one edge after its cause. Directed checks at points chosen after a stimulus cover reset, dropped and ignored writes, clear-to-send holding and the clear strobe.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int PAY_W = 9;

    localparam logic [2:0] MODE_D8  = 3'b001;
    localparam logic [2:0] MODE_D7P = 3'b011;
    localparam logic [2:0] MODE_D9  = 3'b100;
    localparam logic [2:0] MODE_D8W = 3'b101;
    localparam logic [2:0] MODE_D8P = 3'b111;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } phase_e;

    // One character prepared for shifting: payload, its length, stop length in half bits
    typedef struct packed {
        logic [PAY_W-1:0] bits;
        logic [3:0]       nbits;
        logic [2:0]       halves;
    } frame_t;

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int  DEPTH = 16,
    parameter int  WIDTH = 9,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               rd;
        logic [PW-1:0]               wr;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t q, n;
    logic     do_push, do_pop;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;
    assign rdata = q.mem[q.rd];

    always_comb begin
        n       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (clr) begin
            n.rd  = '0;
            n.wr  = '0;
            n.cnt = '0;
        end else begin
            if (do_push) begin
                n.mem[q.wr] = wdata;
                n.wr        = q.wr + PW'(1);
            end
            if (do_pop) begin
                n.rd = q.rd + PW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   n.cnt = q.cnt + CW'(1);
                2'b01:   n.cnt = q.cnt - CW'(1);
                default: n.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // R3: occupancy never exceeds the depth
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R2: a write into a full queue without a pop leaves occupancy unchanged
    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> $stable(q.cnt));

    // R10: a clear strobe leaves the queue empty
    p_clr_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic [2:0]       mode,
    input  logic [1:0]       stop_sel,
    input  logic             parity_odd,
    input  logic [PAY_W-1:0] data,
    output frame_t           frm
);

    logic par7, par8;

    always_comb begin
        par7       = (^data[6:0]) ^ parity_odd;
        par8       = (^data[7:0]) ^ parity_odd;
        frm.halves = {1'b0, stop_sel} + 3'd1;
        case (mode)
            MODE_D7P: begin
                frm.bits  = {1'b0, par7, data[6:0]};
                frm.nbits = 4'd8;
            end
            MODE_D9, MODE_D8W: begin
                frm.bits  = data;
                frm.nbits = 4'd9;
            end
            MODE_D8P: begin
                frm.bits  = {par8, data[7:0]};
                frm.nbits = 4'd9;
            end
            default: begin
                frm.bits  = {1'b0, data[7:0]};
                frm.nbits = 4'd8;
            end
        endcase
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int  OVS  = 16,
    localparam int CW   = $clog2(2 * OVS),
    localparam int HALF = OVS / 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   avail,
    input  logic   cts_ok,
    input  frame_t frm,
    output logic   pop,
    output logic   tx,
    output logic   idle
);

    typedef struct packed {
        phase_e           phase;
        logic [CW-1:0]    cnt;
        logic [3:0]       idx;
        logic [PAY_W-1:0] sh;
        logic [3:0]       nbits;
        logic [2:0]       halves;
        logic             tx;
    } shift_st_t;

    shift_st_t     q, n;
    logic [CW-1:0] stop_lim;
    logic          bit_end, start_ok, do_load;

    assign tx   = q.tx;
    assign idle = (q.phase == PH_IDLE);

    always_comb begin
        n        = q;
        pop      = 1'b0;
        do_load  = 1'b0;
        stop_lim = CW'(int'(q.halves) * HALF - 1);
        bit_end  = (q.cnt == CW'(OVS - 1));
        start_ok = avail && cts_ok;
        if (tick) begin
            case (q.phase)
                PH_IDLE: do_load = start_ok;
                PH_START: begin
                    if (bit_end) begin
                        n.phase = PH_DATA;
                        n.cnt   = '0;
                        n.tx    = q.sh[0];
                        n.sh    = q.sh >> 1;
                        n.idx   = 4'd1;
                    end else begin
                        n.cnt = q.cnt + CW'(1);
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        n.cnt = '0;
                        if (q.idx == q.nbits) begin
                            n.phase = PH_STOP;
                            n.tx    = 1'b1;
                        end else begin
                            n.tx  = q.sh[0];
                            n.sh  = q.sh >> 1;
                            n.idx = q.idx + 4'd1;
                        end
                    end else begin
                        n.cnt = q.cnt + CW'(1);
                    end
                end
                default: begin
                    if (q.cnt == stop_lim) begin
                        if (start_ok) do_load = 1'b1;
                        else          n.phase = PH_IDLE;
                    end else begin
                        n.cnt = q.cnt + CW'(1);
                    end
                end
            endcase
        end
        if (do_load) begin
            pop      = 1'b1;
            n.phase  = PH_START;
            n.cnt    = '0;
            n.idx    = '0;
            n.sh     = frm.bits;
            n.nbits  = frm.nbits;
            n.halves = frm.halves;
            n.tx     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, cnt: '0, idx: '0, sh: '0,
                           nbits: '0, halves: '0, tx: 1'b1};
        else        q <= n;
    end

    // R5: the line rests high between frames
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE) |-> q.tx);

    // R5: every line transition follows a sampled tick
    p_edge_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.tx) |-> $past(tick));

    // R9: with sending blocked an idle serializer stays idle
    p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && !cts_ok) |=> (q.phase == PH_IDLE));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [AW-1:0] DATA_OFS = AW'(4),
    parameter int          DEPTH    = 16,
    parameter int          OVS      = 16,
    localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [PAY_W-1:0] reg_wdata,
    input  logic             fifo_clr,
    input  logic [2:0]       mode,
    input  logic [1:0]       stop_sel,
    input  logic             parity_odd,
    input  logic             cts_gate,
    input  logic [2:1]       irq_en,
    input  logic             baud_tick,
    input  logic             cts,
    output logic             tx,
    output logic [9:0]       status,
    output logic             irq
);

    logic [PAY_W-1:0] head;
    logic [CNT_W-1:0] fill;
    logic             q_empty, q_full, pop, push, ser_idle, cts_ok;
    logic             st_empty, st_half;
    frame_t           frm;

    assign push   = reg_wr && (reg_addr == DATA_OFS);
    assign cts_ok = !cts_gate || cts;

    sertx_fifo #(.DEPTH(DEPTH), .WIDTH(PAY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (push),
        .wdata (reg_wdata),
        .pop   (pop),
        .rdata (head),
        .count (fill),
        .empty (q_empty),
        .full  (q_full)
    );

    sertx_framer u_framer (
        .mode       (mode),
        .stop_sel   (stop_sel),
        .parity_odd (parity_odd),
        .data       (head),
        .frm        (frm)
    );

    sertx_shifter #(.OVS(OVS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud_tick),
        .avail  (!q_empty),
        .cts_ok (cts_ok),
        .frm    (frm),
        .pop    (pop),
        .tx     (tx),
        .idle   (ser_idle)
    );

    always_comb begin
        st_empty  = q_empty && ser_idle;
        st_half   = (fill <= CNT_W'(DEPTH / 2));
        status    = '0;
        status[1] = st_empty;
        status[2] = st_half;
        status[9] = q_full;
        irq       = (irq_en[1] && st_empty) || (irq_en[2] && st_half);
    end

    // R4: transmitter-empty implies the line is at rest
    p_empty_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> tx);

    // R3: full and half-empty are never reported together
    p_full_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[9] && status[2]));

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_addr = 0;
    logic [8:0] reg_wdata = 0;
    logic       fifo_clr = 0;
    logic [2:0] mode = 3'b001;
    logic [1:0] stop_sel = 2'b01;
    logic       parity_odd = 0;
    logic       cts_gate = 0;
    logic [2:1] irq_en = 0;
    logic       baud_tick = 0;
    logic       cts = 1;
    logic       tx;
    logic [9:0] status;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int tick_per = 2;
    int tdiv = 0;
    bit done = 0;
    bit cmp_on = 0;

    // behavioural reference
    int q[$];
    int ph = 0, cnt = 0, idx = 0, nb = 0, halves = 1;
    int bits[9];
    bit mtx = 1;

    always #5 clk = ~clk;

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fifo_clr(fifo_clr), .mode(mode),
        .stop_sel(stop_sel), .parity_odd(parity_odd), .cts_gate(cts_gate),
        .irq_en(irq_en), .baud_tick(baud_tick), .cts(cts), .tx(tx),
        .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void load_frame();
        int d, ones;
        d = q[0];
        case (mode)
            3'b011: begin
                nb = 8;
                for (int i = 0; i < 7; i++) bits[i] = (d >> i) & 1;
                ones = $countones(d & 'h7f);
                bits[7] = (ones % 2) ^ int'(parity_odd);
            end
            3'b100, 3'b101: begin
                nb = 9;
                for (int i = 0; i < 9; i++) bits[i] = (d >> i) & 1;
            end
            3'b111: begin
                nb = 9;
                for (int i = 0; i < 8; i++) bits[i] = (d >> i) & 1;
                ones = $countones(d & 'hff);
                bits[8] = (ones % 2) ^ int'(parity_odd);
            end
            default: begin
                nb = 8;
                for (int i = 0; i < 8; i++) bits[i] = (d >> i) & 1;
            end
        endcase
        halves = int'(stop_sel) + 1;
        mtx = 0; ph = 1; cnt = 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); ph = 0; cnt = 0; mtx = 1;
        end else begin
            bit full_pre, ok, popped;
            full_pre = (q.size() == 16);
            ok = !cts_gate || cts;
            popped = 0;
            if (baud_tick) begin
                case (ph)
                    0: if (q.size() > 0 && ok) begin load_frame(); popped = 1; end
                    1: if (cnt == 15) begin ph = 2; cnt = 0; mtx = bits[0][0]; idx = 1; end
                       else cnt++;
                    2: if (cnt == 15) begin
                           cnt = 0;
                           if (idx == nb) begin ph = 3; mtx = 1; end
                           else begin mtx = bits[idx][0]; idx++; end
                       end else cnt++;
                    default: if (cnt == halves * 8 - 1) begin
                           if (q.size() > 0 && ok) begin load_frame(); popped = 1; end
                           else ph = 0;
                       end else cnt++;
                endcase
            end
            if (fifo_clr) q.delete();
            else begin
                if (popped) void'(q.pop_front());
                if (reg_wr && reg_addr == 8'h04 && !full_pre) q.push_back(int'(reg_wdata));
            end
        end
    end

    function automatic int exp_status();
        int s;
        s = 0;
        if (q.size() == 0 && ph == 0) s |= 'h2;
        if (q.size() <= 8) s |= 'h4;
        if (q.size() == 16) s |= 'h200;
        return s;
    endfunction

    always @(negedge clk) begin
        baud_tick = (tdiv == 0);
        tdiv = (tdiv + 1) % tick_per;
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            int es;
            es = exp_status();
            chk("R5/R6/R7/R8/R12 tx line", int'(tx), int'(mtx));
            chk("R3/R4 status word", int'(status), es);
            chk("R11 irq", int'(irq),
                int'((irq_en[1] && es[1]) || (irq_en[2] && es[2])));
        end
    end

    task automatic put(input logic [7:0] a, input logic [8:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (q.size() == 0 && ph == 0) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx after reset", int'(tx), 1);
        chk("R1 status after reset", int'(status), 'h006);
        chk("R1 irq after reset", int'(irq), 0);
        cmp_on = 1;
        irq_en = 2'b01;

        // R2 other address ignored
        put(8'h08, 9'h0AA);
        chk("R2 write to other address ignored", int'(status[1]), 1);

        // basic frames, 8-bit, one stop
        put(8'h04, 9'h055); put(8'h04, 9'h1C3); put(8'h04, 9'h000);
        wait_empty();

        // R9/R3/R2: hold with CTS low, fill and overfill
        irq_en = 2'b11;
        tick_per = 1;
        cts_gate = 1; cts = 0;
        for (int i = 0; i < 17; i++) put(8'h04, 9'((i * 37 + 5) & 'h1ff));
        chk("R3 full flag at 16 entries", int'(status[9]), 1);
        repeat (200) @(negedge clk);
        chk("R9 no frame while cts low", int'(tx), 1);
        chk("R2 dropped write keeps 16", int'(status[9]), 1);
        cts = 1;
        wait_empty();
        cts_gate = 0;

        // R6/R7/R8 all formats and stop lengths
        for (int m = 0; m < 5; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int o = 0; o < 2; o++) begin
                    logic [2:0] ml;
                    ml = (m == 0) ? 3'b001 : (m == 1) ? 3'b011 : (m == 2) ? 3'b100 :
                         (m == 3) ? 3'b101 : 3'b111;
                    mode = ml; stop_sel = 2'(s); parity_odd = o[0];
                    tick_per = (s % 2) + 1;
                    put(8'h04, 9'((m * 91 + s * 13 + o * 200) & 'h1ff));
                    put(8'h04, 9'((m * 17 + s * 71 + o) & 'h1ff));
                    wait_empty();
                end
            end
        end

        // R9 frame in progress completes after cts drops
        tick_per = 1; mode = 3'b001; stop_sel = 2'b01;
        cts_gate = 1; cts = 1;
        put(8'h04, 9'h0F0); put(8'h04, 9'h00F);
        repeat (60) @(negedge clk);
        cts = 0;
        repeat (400) @(negedge clk);
        chk("R9 second frame held", int'(status[1]), 0);
        chk("R9 line idle while held", int'(tx), 1);
        cts = 1;
        wait_empty();
        cts_gate = 0;

        // R12 change format mid-frame
        put(8'h04, 9'h1A5);
        repeat (50) @(negedge clk);
        mode = 3'b111; stop_sel = 2'b11; parity_odd = 1;
        put(8'h04, 9'h03C);
        wait_empty();

        // R10 clear while shifting, with a write in the same cycle
        mode = 3'b001; stop_sel = 2'b00;
        for (int i = 0; i < 5; i++) put(8'h04, 9'(i * 29 + 1));
        repeat (30) @(negedge clk);
        @(negedge clk);
        fifo_clr = 1; reg_wr = 1; reg_addr = 8'h04; reg_wdata = 9'h111;
        @(negedge clk);
        fifo_clr = 0; reg_wr = 0;
        chk("R10 half flag after clear", int'(status[2]), 1);
        chk("R10 frame still running", int'(status[1]), 0);
        wait_empty();
        chk("R10 empty after current frame", int'(status[1]), 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule